// File: doc/BRIEF.md
# Operand Resolver

This block is the operand stage of a small 16-bit word-addressed processor. It is given one 6-bit operand code, taken from one of the two operand fields of an instruction word. It works out whether that operand is a register, a RAM word or a constant, and returns three things: the operand's value, its location and a kind code. It also keeps a running total of the cycle cost of everything it has resolved.

Some modes read the word that follows the instruction, and doing so advances the program counter. The stack modes move the stack pointer. The program counter, the stack pointer and the overflow register are held inside the block.

A second path, the write-back, takes a kind, a location and a value, usually ones that an earlier resolution returned, and stores the value there. The eight general registers live in an external register file. The external RAM has a single port and returns read data one cycle after the address.

Top module: `operand_resolver`

## Requirements
- R1: Codes 0x00..0x07 return the general register with that index (0=A … 7=J). The kind is register (1), the location is the code, and no cycles are added.
- R2: Codes 0x08..0x0F read RAM at the address held in general register (code−8). The kind is memory (2), the location is that address, and 1 cycle is added.
- R3: Codes 0x10..0x17 read the next word at PC and increment PC. They then read RAM at general register (code−16) plus that word, modulo 2^16. The kind is memory, and 2 cycles are added.
- R4: Code 0x1A (push) decrements SP and then uses RAM at the new SP. Code 0x19 (peek) uses RAM at SP and leaves SP unchanged. Code 0x18 (pop) uses RAM at SP and then increments SP. Each returns kind memory with the RAM address as location, and adds 1 cycle. SP arithmetic wraps, so a push straight after reset uses 0xFFFF.
- R5: With skip asserted at start, push and pop leave SP unchanged. They return kind literal (0) with value 0 and location 0, and still add 1 cycle.
- R6: Codes 0x1B, 0x1C and 0x1D return SP, PC and the overflow register O respectively. The kind is register, the location is the code, and no cycles are added.
- R7: Code 0x1E reads the next word, increments PC and reads RAM at that word; it returns kind memory and adds 2 cycles. Code 0x1F reads the next word, increments PC and returns that word as a literal value and location; it adds 1 cycle.
- R8: Codes 0x20..0x3F return a literal equal to code−0x20, with the same number as location, and add no cycles.
- R9: A write-back of kind memory writes the value to RAM at the location and adds 1 cycle.
- R10: A write-back of kind register writes general register loc (for loc 0..7), SP (0x1B), PC (0x1C) or O (0x1D). It adds no cycles.
- R11: A write-back of kind literal changes no register and no RAM word, and adds no cycles.
- R12: After a synchronous active-high reset, PC, SP, O and the cycle count are 0 and done is low. The done and wb_done outputs are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving `code` (takes priority over write-back) |
| code | input | 6 | Operand code |
| skip | input | 1 | Current instruction is being skipped |
| done | output | 1 | One-cycle pulse: operand outputs valid |
| op_value | output | W | Resolved value |
| op_loc | output | W | Resolved location |
| op_kind | output | 2 | 0 literal, 1 register, 2 memory |
| cycles | output | CW | Accumulated cycle cost |
| wb_start | input | 1 | Begin a write-back |
| wb_kind | input | 2 | Write-back kind |
| wb_loc | input | W | Write-back location |
| wb_value | input | W | Write-back value |
| wb_done | output | 1 | One-cycle pulse: write-back complete |
| gp_sel | output | 3 | General register read select |
| gp_rdata | input | W | General register read data |
| gp_we | output | 1 | General register write enable |
| gp_wsel | output | 3 | General register write select |
| gp_wdata | output | W | General register write data |
| mem_addr | output | W | RAM address |
| mem_rdata | input | W | RAM read data, one cycle after address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | W | RAM write data |
| pc | output | W | Program counter |
| sp | output | W | Stack pointer |
| ov | output | W | Overflow register |

## Verification
The bench builds the block with W=16 and CW=16. With these values the 16-bit wrap is reachable: the first push after reset must address 0xFFFF, and a register-plus-offset sum such as 0x0080+0xFFF0 must fold to 0x0070. The bench's RAM model aliases addresses to 1024 words. The chosen addresses are kept distinct, so every memory value the bench expects identifies exactly one location.

// File: rtl/operand_resolver.sv
module operand_resolver #(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [5:0]    code,
  input  logic          skip,
  output logic          done,
  output logic [W-1:0]  op_value,
  output logic [W-1:0]  op_loc,
  output logic [1:0]    op_kind,
  output logic [CW-1:0] cycles,
  input  logic          wb_start,
  input  logic [1:0]    wb_kind,
  input  logic [W-1:0]  wb_loc,
  input  logic [W-1:0]  wb_value,
  output logic          wb_done,
  output logic [2:0]    gp_sel,
  input  logic [W-1:0]  gp_rdata,
  output logic          gp_we,
  output logic [2:0]    gp_wsel,
  output logic [W-1:0]  gp_wdata,
  output logic [W-1:0]  mem_addr,
  input  logic [W-1:0]  mem_rdata,
  output logic          mem_we,
  output logic [W-1:0]  mem_wdata,
  output logic [W-1:0]  pc,
  output logic [W-1:0]  sp,
  output logic [W-1:0]  ov
);
  localparam logic [1:0] K_LIT = 2'd0, K_REG = 2'd1, K_MEM = 2'd2;
  localparam logic [5:0] C_POP = 6'h18, C_PEEK = 6'h19, C_PUSH = 6'h1A,
                         C_SP = 6'h1B, C_PC = 6'h1C, C_OV = 6'h1D,
                         C_NWA = 6'h1E, C_NWL = 6'h1F;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_NXT, S_MRD, S_WB} state_t;
  state_t state;

  logic [5:0]   code_q;
  logic         skip_q;
  logic [W-1:0] loc_q;
  logic [1:0]   wkind_q;
  logic [W-1:0] wloc_q, wval_q;

  logic         fin;
  logic [1:0]   f_kind;
  logic [W-1:0] f_val, f_loc;

  wire nw_idx  = (code_q[5:3] == 3'b010);
  wire nw_any  = nw_idx || code_q == C_NWA || code_q == C_NWL;
  wire stk_mod = (code_q == C_POP) || (code_q == C_PUSH);

  function automatic logic [1:0] cost_of(logic [5:0] c);
    if (c[5])                          return 2'd0;
    else if (c[4:3] == 2'b00)          return 2'd0;
    else if (c[4:3] == 2'b01)          return 2'd1;
    else if (c[4:3] == 2'b10)          return 2'd2;
    else if (c <= C_PUSH)              return 2'd1;
    else if (c == C_NWA)               return 2'd2;
    else if (c == C_NWL)               return 2'd1;
    else                               return 2'd0;
  endfunction

  assign gp_sel    = code_q[2:0];
  assign gp_we     = (state == S_WB) && (wkind_q == K_REG) && (wloc_q < W'(8));
  assign gp_wsel   = wloc_q[2:0];
  assign gp_wdata  = wval_q;
  assign mem_we    = (state == S_WB) && (wkind_q == K_MEM);
  assign mem_wdata = wval_q;

  always_comb begin
    mem_addr = '0;
    case (state)
      S_DEC:
        if (code_q[5:3] == 3'b001) mem_addr = gp_rdata;
        else if (nw_any)           mem_addr = pc;
        else if (code_q == C_PUSH) mem_addr = sp - W'(1);
        else                       mem_addr = sp;
      S_NXT:   mem_addr = nw_idx ? gp_rdata + mem_rdata : mem_rdata;
      S_WB:    mem_addr = wloc_q;
      default: mem_addr = '0;
    endcase
  end

  always_comb begin
    fin = 1'b0; f_kind = K_LIT; f_val = '0; f_loc = '0;
    case (state)
      S_DEC:
        if (code_q[5]) begin
          fin = 1'b1; f_val = W'(code_q[4:0]); f_loc = W'(code_q[4:0]);
        end else if (code_q[4:3] == 2'b00) begin
          fin = 1'b1; f_kind = K_REG; f_val = gp_rdata; f_loc = W'(code_q);
        end else if (stk_mod && skip_q) begin
          fin = 1'b1;
        end else if (code_q == C_SP || code_q == C_PC || code_q == C_OV) begin
          fin = 1'b1; f_kind = K_REG; f_loc = W'(code_q);
          f_val = (code_q == C_SP) ? sp : (code_q == C_PC) ? pc : ov;
        end
      S_NXT:
        if (code_q == C_NWL) begin
          fin = 1'b1; f_val = mem_rdata; f_loc = mem_rdata;
        end
      S_MRD: begin
        fin = 1'b1; f_kind = K_MEM; f_val = mem_rdata; f_loc = loc_q;
      end
      default: fin = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; done <= 1'b0; wb_done <= 1'b0;
      pc <= '0; sp <= '0; ov <= '0; cycles <= '0;
      op_value <= '0; op_loc <= '0; op_kind <= K_LIT;
      code_q <= '0; skip_q <= 1'b0; loc_q <= '0;
      wkind_q <= K_LIT; wloc_q <= '0; wval_q <= '0;
    end else begin
      done <= 1'b0;
      wb_done <= 1'b0;
      if (fin) begin
        op_kind <= f_kind; op_value <= f_val; op_loc <= f_loc;
        done <= 1'b1;
        cycles <= cycles + CW'(cost_of(code_q));
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE:
            if (start) begin
              code_q <= code; skip_q <= skip; state <= S_DEC;
            end else if (wb_start) begin
              wkind_q <= wb_kind; wloc_q <= wb_loc; wval_q <= wb_value; state <= S_WB;
            end
          S_DEC: begin
            loc_q <= mem_addr;
            if (nw_any) begin
              pc <= pc + W'(1); state <= S_NXT;
            end else begin
              if (code_q == C_POP)  sp <= sp + W'(1);
              if (code_q == C_PUSH) sp <= sp - W'(1);
              state <= S_MRD;
            end
          end
          S_NXT: begin
            loc_q <= mem_addr; state <= S_MRD;
          end
          S_WB: begin
            if (wkind_q == K_MEM) cycles <= cycles + CW'(1);
            if (wkind_q == K_REG) begin
              if (wloc_q == W'(C_SP)) sp <= wval_q;
              if (wloc_q == W'(C_PC)) pc <= wval_q;
              if (wloc_q == W'(C_OV)) ov <= wval_q;
            end
            wb_done <= 1'b1; state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_wb_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    wb_done |=> !wb_done);
  p_pop_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && code_q == C_POP && !skip_q) |=> sp == $past(sp) + W'(1));
  p_push_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && code_q == C_PUSH && !skip_q) |=> sp == $past(sp) - W'(1));
  p_skip_sp_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && stk_mod && skip_q) |=> (sp == $past(sp)) && done && op_kind == K_LIT);
  p_next_pc_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && nw_any) |=> pc == $past(pc) + W'(1));
  p_lit_free_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && code_q[5]) |=> cycles == $past(cycles));
  p_lit_wb_r11: assert property (@(posedge clk) disable iff (rst)
    (state == S_WB && wkind_q == K_LIT) |-> !mem_we && !gp_we);
  p_lit_wb_keep_r11: assert property (@(posedge clk) disable iff (rst)
    (state == S_WB && wkind_q == K_LIT) |=> $stable(cycles) && $stable(sp) && $stable(pc) && $stable(ov));
endmodule

// File: tb/test_operand_resolver.sv
module test_operand_resolver;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, start, skip, done, wb_start, wb_done, gp_we, mem_we;
  logic [5:0] code;
  logic [15:0] op_value, op_loc, wb_loc, wb_value, gp_rdata, gp_wdata;
  logic [15:0] mem_addr, mem_rdata, mem_wdata, pc, sp, ov, cycles;
  logic [1:0] op_kind, wb_kind;
  logic [2:0] gp_sel, gp_wsel;

  logic [15:0] ram [1024];
  logic [15:0] gp [8];
  logic [15:0] ram_q;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
    ram_q <= ram[mem_addr[9:0]];
    if (gp_we) gp[gp_wsel] <= gp_wdata;
  end
  assign mem_rdata = ram_q;
  assign gp_rdata  = gp[gp_sel];

  operand_resolver #(.W(16), .CW(16)) i_operand_resolver (
    .clk(clk), .rst(rst), .start(start), .code(code), .skip(skip), .done(done),
    .op_value(op_value), .op_loc(op_loc), .op_kind(op_kind), .cycles(cycles),
    .wb_start(wb_start), .wb_kind(wb_kind), .wb_loc(wb_loc), .wb_value(wb_value),
    .wb_done(wb_done), .gp_sel(gp_sel), .gp_rdata(gp_rdata), .gp_we(gp_we),
    .gp_wsel(gp_wsel), .gp_wdata(gp_wdata), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .pc(pc), .sp(sp), .ov(ov));

  int errors = 0, checks = 0;
  logic [15:0] exp_cyc = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic run_op(input logic [5:0] c, input logic s);
    bit seen = 0;
    @(negedge clk); start = 1'b1; code = c; skip = s;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R12 done seen", 16'(seen), 16'd1);
  endtask

  task automatic run_wb(input logic [1:0] k, input logic [15:0] l, input logic [15:0] v);
    bit seen = 0;
    @(negedge clk); wb_start = 1'b1; wb_kind = k; wb_loc = l; wb_value = v;
    @(negedge clk); wb_start = 1'b0;
    for (int n = 0; n < 20; n++) begin
      if (wb_done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R12 wb_done seen", 16'(seen), 16'd1);
  endtask

  typedef struct packed {
    logic [5:0] c; logic s; logic [1:0] kind; logic [15:0] val;
    logic [15:0] loc; logic [3:0] cost; logic [15:0] epc; logic [15:0] esp;
  } vec_t;

  localparam vec_t TBL [16] = '{
    '{6'h03, 1'b0, 2'd1, 16'h0040, 16'h0003, 4'd0, 16'h0000, 16'h0000}, // R1
    '{6'h0A, 1'b0, 2'd2, 16'h5A30, 16'h0030, 4'd1, 16'h0000, 16'h0000}, // R2
    '{6'h11, 1'b0, 2'd2, 16'h5A25, 16'h0025, 4'd2, 16'h0001, 16'h0000}, // R3
    '{6'h1E, 1'b0, 2'd2, 16'h5B00, 16'h0100, 4'd2, 16'h0002, 16'h0000}, // R7
    '{6'h1F, 1'b0, 2'd0, 16'hBEEF, 16'hBEEF, 4'd1, 16'h0003, 16'h0000}, // R7
    '{6'h3F, 1'b0, 2'd0, 16'h001F, 16'h001F, 4'd0, 16'h0003, 16'h0000}, // R8
    '{6'h20, 1'b0, 2'd0, 16'h0000, 16'h0000, 4'd0, 16'h0003, 16'h0000}, // R8
    '{6'h1A, 1'b0, 2'd2, 16'h59FF, 16'hFFFF, 4'd1, 16'h0003, 16'hFFFF}, // R4 push wraps
    '{6'h19, 1'b0, 2'd2, 16'h59FF, 16'hFFFF, 4'd1, 16'h0003, 16'hFFFF}, // R4 peek
    '{6'h18, 1'b0, 2'd2, 16'h59FF, 16'hFFFF, 4'd1, 16'h0003, 16'h0000}, // R4 pop
    '{6'h1B, 1'b0, 2'd1, 16'h0000, 16'h001B, 4'd0, 16'h0003, 16'h0000}, // R6
    '{6'h1C, 1'b0, 2'd1, 16'h0003, 16'h001C, 4'd0, 16'h0003, 16'h0000}, // R6
    '{6'h1D, 1'b0, 2'd1, 16'h0000, 16'h001D, 4'd0, 16'h0003, 16'h0000}, // R6
    '{6'h1A, 1'b1, 2'd0, 16'h0000, 16'h0000, 4'd1, 16'h0003, 16'h0000}, // R5
    '{6'h18, 1'b1, 2'd0, 16'h0000, 16'h0000, 4'd1, 16'h0003, 16'h0000}, // R5
    '{6'h17, 1'b0, 2'd2, 16'h5A70, 16'h0070, 4'd2, 16'h0004, 16'h0000}  // R3 wrap
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) ram[i] = 16'(i) ^ 16'h5A00;
    ram[0] = 16'h0005; ram[1] = 16'h0100; ram[2] = 16'hBEEF; ram[3] = 16'hFFF0;
    for (int i = 0; i < 8; i++) gp[i] = 16'h0010 * 16'(i + 1);
    rst = 1'b1; start = 1'b0; code = '0; skip = 1'b0;
    wb_start = 1'b0; wb_kind = '0; wb_loc = '0; wb_value = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset pc", pc, 16'h0);
    chk("R12 reset sp", sp, 16'h0);
    chk("R12 reset ov", ov, 16'h0);
    chk("R12 reset cycles", cycles, 16'h0);
    chk("R12 reset done", 16'(done), 16'h0);

    for (int v = 0; v < 16; v++) begin
      run_op(TBL[v].c, TBL[v].s);
      exp_cyc += 16'(TBL[v].cost);
      chk($sformatf("vec%0d value", v), op_value, TBL[v].val);
      chk($sformatf("vec%0d loc", v), op_loc, TBL[v].loc);
      chk($sformatf("vec%0d kind", v), 16'(op_kind), 16'(TBL[v].kind));
      chk($sformatf("vec%0d pc", v), pc, TBL[v].epc);
      chk($sformatf("vec%0d sp", v), sp, TBL[v].esp);
      chk($sformatf("vec%0d cycles", v), cycles, exp_cyc);
      @(negedge clk);
      chk("R12 done pulse one cycle", 16'(done), 16'h0);
    end

    // R9 memory write-back, then read it back through X-indirect mode (R2)
    run_wb(2'd2, 16'h0040, 16'h1234);
    exp_cyc += 1;
    chk("R9 ram written", ram[16'h0040], 16'h1234);
    chk("R9 cycle added", cycles, exp_cyc);
    run_op(6'h0B, 1'b0);
    exp_cyc += 1;
    chk("R9 readback", op_value, 16'h1234);

    // R10 register write-backs
    run_wb(2'd1, 16'h0005, 16'hCAFE);
    chk("R10 gp Z written", gp[5], 16'hCAFE);
    chk("R10 no cycle", cycles, exp_cyc);
    run_op(6'h05, 1'b0);
    chk("R10 gp Z readback", op_value, 16'hCAFE);
    run_wb(2'd1, 16'h001D, 16'h7777);
    chk("R10 ov written", ov, 16'h7777);
    run_wb(2'd1, 16'h001B, 16'h0010);
    chk("R10 sp written", sp, 16'h0010);
    run_wb(2'd1, 16'h001C, 16'h0200);
    chk("R10 pc written", pc, 16'h0200);
    run_op(6'h1D, 1'b0);
    chk("R10 ov readback", op_value, 16'h7777);

    // R11 literal write-back discarded
    run_wb(2'd0, 16'h0003, 16'hDEAD);
    chk("R11 gp X kept", gp[3], 16'h0040);
    chk("R11 ram kept", ram[16'h0003], 16'hFFF0);
    chk("R11 no cycle", cycles, exp_cyc);
    chk("R11 pc kept", pc, 16'h0200);
    run_op(6'h03, 1'b0);
    chk("R11 X readback", op_value, 16'h0040);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule